// File: doc/BRIEF.md
# Disc Decoder Control and Status Registers

This block is the host-facing register set of an optical-disc data decoder. It decodes one shared host address for two purposes. A write there, whatever the data, starts a firmware reset. A read there returns a status byte that summarises the block the decoder most recently finished. A second address takes a control byte. That byte holds the decoder's enable bits, and they drive the decoder core directly as plain output pins.

The decoder core reports what happens in each block through single-cycle event inputs. These are header/pointer/status available, a byte was corrected, and a C2 pointer flag was seen. The block gathers these events in accumulators while a block is in progress. On the block-end strobe it moves them into the readable status, then clears the accumulators. Host reads therefore always see a complete block, never a partial one. All pins are plain control and status signals; there is no streaming interface, so no back-pressure applies.

Top module: `dcr_top`

## Requirements
- R1: A host write to the reset address (default 0x0F), with any data value, drives `fw_rst_pulse` high for exactly the one cycle after the write edge.
- R2: A firmware reset sets `fw_rst_flag`. The flag stays set until chip reset (`rst_n` low) or `host_rst`.
- R3: A write to the control address (default 0x10) loads the control outputs on the next edge from these data bits: bit 6 → `sync_wen`, bit 5 → `sub_align`, bit 4 → `dsp_clk_en`, bit 2 → `c2_wen`. Data bits 7, 3 and 0 have no effect.
- R4: The control outputs become all zero after chip reset, and at the edge where any of these occurs: `host_rst`, `dec_rst`, or a write to the reset address. Reset takes priority over a control write.
- R5: A read (`rd_en`) at the reset address returns the status byte on `rdata` in the same cycle and does not start a firmware reset. Otherwise `rdata` is 0.
- R6: Status bit 7 is 1 when `ev_valid` pulsed during the last completed block.
- R7: Status bit 5 is 1 when `ev_corr` pulsed during the last completed block.
- R8: Status bit 1 is 1 only when `ev_c2` pulsed during the last completed block while `c2_wen` was 1. A C2 event while `c2_wen` is 0 is not recorded.
- R9: Status bits 6, 4, 3, 2 and 0 always read 0.
- R10: The status changes only at a `blk_end` edge. An event on the `blk_end` cycle counts toward the block that is ending, and the accumulators start the next block cleared.
- R11: Chip reset and `dec_rst` clear both the status and the accumulators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| host_rst | input | 1 | Host reset, synchronous |
| dec_rst | input | 1 | Decoder reset, synchronous |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| blk_end | input | 1 | Block boundary strobe |
| ev_valid | input | 1 | Header/pointer/status available event |
| ev_corr | input | 1 | Byte corrected event |
| ev_c2 | input | 1 | C2 pointer flag seen event |
| sync_wen | output | 1 | Synchronized write enable |
| sub_align | output | 1 | Subcode/serial sync alignment enable |
| dsp_clk_en | output | 1 | Use DSP clock in decoder |
| c2_wen | output | 1 | C2 flag write enable |
| fw_rst_pulse | output | 1 | One-cycle firmware reset pulse |
| fw_rst_flag | output | 1 | Sticky firmware reset indicator |

## Verification
The bench builds the block with its defaults: an 8-bit address, reset/status at 0x0F and control at 0x10. These values match the decode a host driver would use, and they allow both reserved-data patterns (0xFF, 0x00) to be written to each address. It also drives the reset address with a non-matching neighbour (0x0E), which shows that only the exact address fires a reset. The block-event scenarios drive C2 events with `c2_wen` both set and clear, and place events on the boundary cycle itself.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int DATA_W = 8;
  localparam int CB_SWEN = 6;
  localparam int CB_SUB  = 5;
  localparam int CB_DSP  = 4;
  localparam int CB_C2W  = 2;
  localparam int SB_VAL  = 7;
  localparam int SB_COR  = 5;
  localparam int SB_C2   = 1;

  typedef struct packed {
    logic sync_wen;
    logic sub_align;
    logic dsp_clk;
    logic c2_wen;
  } ctrl_t;

  typedef struct packed {
    logic valid;
    logic corr;
    logic c2;
  } stat_t;

  function automatic logic [DATA_W-1:0] stat_byte(stat_t s);
    logic [DATA_W-1:0] b;
    b = '0;
    b[SB_VAL] = s.valid;
    b[SB_COR] = s.corr;
    b[SB_C2]  = s.c2;
    return b;
  endfunction
endpackage

// File: rtl/dcr_ctrl_reg.sv
module dcr_ctrl_reg
  import dcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] RST_ADDR  = 8'h0F,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rst,
  input  logic              dec_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic              fw_pulse,
  output logic              fw_flag
);
  logic  fw_hit, ctrl_hit, clr;
  ctrl_t ctrl_q;
  logic  unused_rsvd;

  assign fw_hit   = wr_en && (addr == RST_ADDR);
  assign ctrl_hit = wr_en && (addr == CTRL_ADDR);
  assign clr      = host_rst || dec_rst || fw_hit;
  assign unused_rsvd = ^{wdata[7], wdata[3], wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      fw_pulse <= 1'b0;
      fw_flag  <= 1'b0;
    end else begin
      fw_pulse <= fw_hit;
      if (host_rst)    fw_flag <= 1'b0;
      else if (fw_hit) fw_flag <= 1'b1;
      if (clr) ctrl_q <= '0;
      else if (ctrl_hit) begin
        ctrl_q.sync_wen  <= wdata[CB_SWEN];
        ctrl_q.sub_align <= wdata[CB_SUB];
        ctrl_q.dsp_clk   <= wdata[CB_DSP];
        ctrl_q.c2_wen    <= wdata[CB_C2W];
      end
    end
  end

  assign ctrl = ctrl_q;

  AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fw_pulse |-> $past(wr_en && (addr == RST_ADDR))); // R1
  AST_PULSE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && (addr == RST_ADDR)) |-> !fw_pulse); // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fw_flag) && !$past(host_rst)) |-> fw_flag); // R2
  AST_CTRL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_rst || dec_rst || (wr_en && (addr == RST_ADDR))) |-> (ctrl == '0)); // R4
endmodule

// File: rtl/dcr_blk_flags.sv
module dcr_blk_flags
  import dcr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dec_rst,
  input  logic  blk_end,
  input  logic  ev_valid,
  input  logic  ev_corr,
  input  logic  ev_c2,
  input  logic  c2_wen,
  output stat_t status
);
  stat_t acc_q, acc_nx, stat_q;

  always_comb begin
    acc_nx.valid = acc_q.valid | ev_valid;
    acc_nx.corr  = acc_q.corr  | ev_corr;
    acc_nx.c2    = acc_q.c2    | (ev_c2 & c2_wen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      stat_q <= '0;
    end else if (dec_rst) begin
      acc_q  <= '0;
      stat_q <= '0;
    end else if (blk_end) begin
      stat_q <= acc_nx;
      acc_q  <= '0;
    end else begin
      acc_q  <= acc_nx;
    end
  end

  assign status = stat_q;

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(blk_end) && !$past(dec_rst)) |-> $stable(status)); // R10
  AST_C2_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status.c2) |-> $past(blk_end)); // R8
  AST_DEC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dec_rst) |-> (status == '0)); // R11
endmodule

// File: rtl/dcr_top.sv
module dcr_top
  import dcr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] RST_ADDR  = 8'h0F,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rst,
  input  logic              dec_rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              blk_end,
  input  logic              ev_valid,
  input  logic              ev_corr,
  input  logic              ev_c2,
  output logic              sync_wen,
  output logic              sub_align,
  output logic              dsp_clk_en,
  output logic              c2_wen,
  output logic              fw_rst_pulse,
  output logic              fw_rst_flag
);
  ctrl_t ctrl;
  stat_t status;

  dcr_ctrl_reg #(.ADDR_W(ADDR_W), .RST_ADDR(RST_ADDR), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .dec_rst(dec_rst),
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl(ctrl), .fw_pulse(fw_rst_pulse), .fw_flag(fw_rst_flag)
  );

  dcr_blk_flags u_flags (
    .clk(clk), .rst_n(rst_n), .dec_rst(dec_rst), .blk_end(blk_end),
    .ev_valid(ev_valid), .ev_corr(ev_corr), .ev_c2(ev_c2),
    .c2_wen(ctrl.c2_wen), .status(status)
  );

  assign sync_wen   = ctrl.sync_wen;
  assign sub_align  = ctrl.sub_align;
  assign dsp_clk_en = ctrl.dsp_clk;
  assign c2_wen     = ctrl.c2_wen;

  assign rdata = (rd_en && (addr == RST_ADDR)) ? stat_byte(status) : '0;

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0)); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & 8'h5D) == 8'h00); // R9
endmodule

// File: tb/dcr_top_tb.sv
module dcr_top_tb;
  logic clk = 1'b0, rst_n = 1'b0, host_rst = 1'b0, dec_rst = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, blk_end = 1'b0;
  logic ev_valid = 1'b0, ev_corr = 1'b0, ev_c2 = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic sync_wen, sub_align, dsp_clk_en, c2_wen, fw_rst_pulse, fw_rst_flag;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] RA = 8'h0F, CA = 8'h10;

  always #5 clk = ~clk;

  dcr_top u_dut (
    .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .dec_rst(dec_rst),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .blk_end(blk_end), .ev_valid(ev_valid), .ev_corr(ev_corr), .ev_c2(ev_c2),
    .sync_wen(sync_wen), .sub_align(sub_align), .dsp_clk_en(dsp_clk_en),
    .c2_wen(c2_wen), .fw_rst_pulse(fw_rst_pulse), .fw_rst_flag(fw_rst_flag)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl_out();
    return {1'b0, sync_wen, sub_align, dsp_clk_en, 1'b0, c2_wen, 2'b00};
  endfunction

  task automatic hwrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic hread(output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = RA; #1 v = rdata; rd_en = 1'b0;
  endtask

  task automatic blk(bit v, bit c, bit c2, bit e);
    @(negedge clk); ev_valid = v; ev_corr = c; ev_c2 = c2; blk_end = e;
    @(negedge clk); ev_valid = 0; ev_corr = 0; ev_c2 = 0; blk_end = 0;
  endtask

  task automatic t_reset_state();
    logic [7:0] s;
    check("R4 ctrl after chip reset", ctl_out(), 8'h00);
    check("R2 flag after chip reset", {7'd0, fw_rst_flag}, 8'h00);
    check("R1 no pulse after reset", {7'd0, fw_rst_pulse}, 8'h00);
    hread(s); check("R11 status after reset", s, 8'h00);
    check("R5 idle rdata", rdata, 8'h00);
  endtask

  task automatic t_ctrl_write();
    hwrite(CA, 8'hFF); check("R3 all ones", ctl_out(), 8'h74);
    hwrite(CA, 8'h89); check("R3 reserved only", ctl_out(), 8'h00);
    hwrite(CA, 8'h54); check("R3 pattern 0x54", ctl_out(), 8'h54);
    hwrite(CA, 8'h20); check("R3 pattern 0x20", ctl_out(), 8'h20);
  endtask

  task automatic t_fw_reset();
    hwrite(CA, 8'h74);
    @(negedge clk); wr_en = 1'b1; addr = 8'h0E; wdata = 8'h00;
    @(posedge clk); #1 check("R1 neighbour addr no pulse", {7'd0, fw_rst_pulse}, 8'h00);
    @(negedge clk); addr = RA; wdata = 8'hA5;
    @(posedge clk); #1 check("R1 pulse high", {7'd0, fw_rst_pulse}, 8'h01);
    check("R2 flag set", {7'd0, fw_rst_flag}, 8'h01);
    check("R4 ctrl cleared by fw reset", ctl_out(), 8'h00);
    @(negedge clk); wr_en = 1'b0;
    @(posedge clk); #1 check("R1 pulse one cycle", {7'd0, fw_rst_pulse}, 8'h00);
    repeat (3) @(posedge clk);
    #1 check("R2 flag sticky", {7'd0, fw_rst_flag}, 8'h01);
    hwrite(RA, 8'h00); check("R1 zero data still fires flag", {7'd0, fw_rst_flag}, 8'h01);
    @(negedge clk); host_rst = 1'b1; @(negedge clk); host_rst = 1'b0;
    check("R2 host reset clears flag", {7'd0, fw_rst_flag}, 8'h00);
  endtask

  task automatic t_read_no_reset();
    logic [7:0] s;
    hwrite(CA, 8'h10);
    @(negedge clk); rd_en = 1'b1; addr = RA;
    @(posedge clk); #1 check("R5 read no pulse", {7'd0, fw_rst_pulse}, 8'h00);
    check("R5 read keeps ctrl", ctl_out(), 8'h10);
    @(negedge clk); addr = CA; #1 check("R5 other addr rdata zero", rdata, 8'h00);
    rd_en = 1'b0;
    hread(s);
  endtask

  task automatic t_host_dec_ctrl();
    hwrite(CA, 8'h74);
    @(negedge clk); host_rst = 1'b1; @(negedge clk); host_rst = 1'b0;
    check("R4 host reset clears ctrl", ctl_out(), 8'h00);
    hwrite(CA, 8'h74);
    @(negedge clk); dec_rst = 1'b1; wr_en = 1'b1; addr = CA; wdata = 8'h74;
    @(negedge clk); dec_rst = 1'b0; wr_en = 1'b0;
    check("R4 dec reset beats write", ctl_out(), 8'h00);
  endtask

  task automatic t_status_block();
    logic [7:0] s;
    hwrite(CA, 8'h04);
    blk(1, 0, 0, 0); blk(0, 1, 0, 0); blk(0, 0, 1, 0);
    hread(s); check("R10 status unchanged mid-block", s, 8'h00);
    blk(0, 0, 0, 1);
    hread(s); check("R6 R7 R8 full block status", s, 8'hA2);
    check("R9 reserved zero", s & 8'h5D, 8'h00);
    blk(1, 0, 0, 0);
    hread(s); check("R10 holds until boundary", s, 8'hA2);
    blk(0, 0, 0, 1);
    hread(s); check("R6 only valid, accum cleared", s, 8'h80);
  endtask

  task automatic t_c2_gate();
    logic [7:0] s;
    hwrite(CA, 8'h00);
    blk(0, 0, 1, 0); blk(0, 0, 0, 1);
    hread(s); check("R8 c2 ignored when disabled", s, 8'h00);
    hwrite(CA, 8'h04);
    blk(0, 0, 1, 0); blk(0, 0, 0, 1);
    hread(s); check("R8 c2 recorded when enabled", s, 8'h02);
  endtask

  task automatic t_boundary_event();
    logic [7:0] s;
    blk(0, 1, 0, 1);
    hread(s); check("R10 boundary event counts", s, 8'h20);
    blk(0, 0, 0, 1);
    hread(s); check("R10 next block empty", s, 8'h00);
  endtask

  task automatic t_dec_reset();
    logic [7:0] s;
    blk(1, 1, 0, 1);
    hread(s); check("R7 corrected block", s, 8'hA0);
    blk(1, 1, 0, 0);
    @(negedge clk); dec_rst = 1'b1; @(negedge clk); dec_rst = 1'b0;
    hread(s); check("R11 dec reset clears status", s, 8'h00);
    blk(0, 0, 0, 1);
    hread(s); check("R11 dec reset clears accum", s, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_ctrl_write();
    t_fw_reset();
    t_read_no_reset();
    t_host_dec_ctrl();
    t_status_block();
    t_c2_gate();
    t_boundary_event();
    t_dec_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule